// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer and Decoder

This block is the control core of a small 8-bit processor whose instructions are all 16 bits wide. Each instruction passes through three phases of one clock each. In the first phase the block captures the instruction word presented at the program address and records the incremented program counter. In the second phase it commits that incremented value to the program counter, or, for a taken subroutine call, to the link register. In the third phase it performs the instruction's effect. The block owns the program counter, the carry, zero and sign flags, and a halted state. The general-purpose register file, the data memory and the arithmetic unit sit outside the block and are reached through plain select, data and strobe ports.

The decoder recognises idle, stop, register copy, load and store (each with an immediate or a pointer address), arithmetic/logic, conditional immediate move, and subroutine call. A jump is the conditional immediate move with the program counter as its destination. A shared three-bit condition field, evaluated against the flags, gates the immediate move, the jump and the call.

Top module: `seq_core`

## Requirements
- R1: After reset the phase output (0 fetch, 1 update, 2 execute) steps 0, 1, 2, 0 on successive clocks, so each instruction takes exactly three clocks.
- R2: Register code 7 names the program counter. Reading it as a source yields the address of the following instruction. Any instruction that does not write the program counter leaves it one above its own address.
- R3: Condition field bits 14:12 decode as 000 always, 001 zero set, 010 sign clear, 011 carry set, 100 carry clear, 101 sign set, 110 zero clear, and 111 never.
- R4: A word with bit 15 set and bit 11 clear writes its low byte into the register coded by bits 10:8 only when the condition holds. With code 7 this is a jump.
- R5: A word of the form 1ccc1111 is a call. When taken, the link register (code 6) receives the return address in the update phase and the program counter receives the low byte in the execute phase. When not taken, the program counter only advances.
- R6: Class 00011 copies the register coded by bits 6:4 into the register coded by bits 10:8.
- R7: Class 00100 loads the register coded by bits 10:8 from the memory address in the low byte. Class 00101 loads it from the address held in the pointer register coded {1, bits 1:0} (M, S, L or PC).
- R8: Classes 00110 and 00111 store the register coded by bits 10:8, using the same two addressing forms as R7, and assert the memory write strobe only in the execute phase.
- R9: For class 01, the block presents operands and pulses the ALU load strobe in the update phase. The first operand is the register coded by bits 6:4. The second is the register coded by bits 2:0, or the zero-extended value of bits 2:0 when bit 7 is set. In the execute phase the flags take the ALU's outputs, and the result is written to the destination only when bit 3 is set.
- R10: Class 00010 sets the halted output. After that no phase advances and the program counter holds until reset.
- R11: Reset sets the program counter to 0, clears all flags and the halted state, and selects the fetch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_in | input | 16 | Instruction word at fetch_addr |
| fetch_addr | output | 8 | Program counter |
| phase_o | output | 2 | Current phase (0 fetch, 1 update, 2 execute) |
| halted | output | 1 | Stop state |
| rd_a_sel | output | 3 | Register file read select, port A |
| rd_a_data | input | 8 | Register file read data, port A |
| rd_b_sel | output | 3 | Register file read select, port B |
| rd_b_data | input | 8 | Register file read data, port B |
| rf_we | output | 1 | Register file write strobe (codes 0 to 6) |
| rf_wsel | output | 3 | Register file write select |
| rf_wdata | output | 8 | Register file write data |
| mem_addr | output | 8 | Data memory address |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Data memory read data |
| alu_load | output | 1 | ALU operand capture strobe |
| alu_kind | output | 3 | ALU operation field |
| alu_unop | output | 2 | ALU unary sub-operation |
| alu_opa | output | 8 | ALU first operand |
| alu_opb | output | 8 | ALU second operand |
| alu_wb | output | 1 | ALU result write-back strobe |
| alu_res | input | 8 | ALU result |
| alu_cy | input | 1 | ALU carry out |
| alu_z | input | 1 | ALU zero out |
| alu_s | input | 1 | ALU sign out |
| flag_cy | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |

## Verification
The assertions assume that the instruction word is stable while the fetch phase is active. They also assume the external ALU returns its result and flags combinationally from the operands it captured on the load strobe. The bench holds each word steady across all three phases, and its ALU model registers operands only on the load strobe. The assertions do not cover self-referencing copies or loads through the register being loaded, whose results are left undefined. The stimulus never issues such words.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_UPD   = 2'd1,
      PH_EXEC  = 2'd2
   } phase_t;

   typedef enum logic [3:0] {
      K_NOP, K_HALT, K_MOV, K_LDI, K_LDP, K_STI, K_STP, K_ALU, K_MOVI, K_CALL
   } kind_t;

   localparam logic [2:0] SEL_LINK = 3'd6;
   localparam logic [2:0] SEL_PC   = 3'd7;

   typedef struct packed {
      kind_t      kind;
      logic [2:0] dst;
      logic [2:0] src_a;
      logic [2:0] src_b;
      logic [2:0] cond;
      logic       use_imm3;
      logic       wb;
   } dec_t;

   function automatic logic cond_eval(logic [2:0] c, logic cy, logic z, logic s);
      case (c)
         3'd0:    cond_eval = 1'b1;
         3'd1:    cond_eval = z;
         3'd2:    cond_eval = !s;
         3'd3:    cond_eval = cy;
         3'd4:    cond_eval = !cy;
         3'd5:    cond_eval = s;
         3'd6:    cond_eval = !z;
         default: cond_eval = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
#(
   parameter int INSN_W = 16
) (
   input  logic [INSN_W-1:0] ir,
   output dec_t              dec
);
   if (INSN_W != 16) begin : g_bad_w
      $error("seq_decode: instruction width must be 16");
   end

   always_comb begin
      dec          = '0;
      dec.kind     = K_NOP;
      dec.dst      = ir[10:8];
      dec.cond     = ir[14:12];
      dec.src_a    = ir[6:4];
      dec.src_b    = ir[2:0];
      dec.use_imm3 = ir[7];
      dec.wb       = ir[3];
      if (ir[15]) begin
         if (!ir[11])                dec.kind = K_MOVI;
         else if (ir[10:8] == 3'b111) dec.kind = K_CALL;
      end else if (ir[14]) begin
         dec.kind = K_ALU;
      end else begin
         case (ir[13:11])
            3'b010:  dec.kind = K_HALT;
            3'b011:  dec.kind = K_MOV;
            3'b100:  dec.kind = K_LDI;
            3'b101:  dec.kind = K_LDP;
            3'b110:  dec.kind = K_STI;
            3'b111:  dec.kind = K_STP;
            default: dec.kind = K_NOP;
         endcase
      end
      // store source rides on port A; pointers ride on port B
      if (dec.kind == K_STI || dec.kind == K_STP) dec.src_a = ir[10:8];
      if (dec.kind == K_LDP || dec.kind == K_STP) dec.src_b = {1'b1, ir[1:0]};
   end
endmodule

// File: rtl/seq_cond.sv
module seq_cond
   import seq_pkg::*;
#(
   parameter int COND_W = 3
) (
   input  logic [COND_W-1:0] code,
   input  logic              cy,
   input  logic              z,
   input  logic              s,
   output logic              taken
);
   localparam int NCODES = 1 << COND_W;

   if (COND_W != 3) begin : g_bad_c
      $error("seq_cond: condition field must be 3 bits");
   end

   logic [NCODES-1:0] truth;

   for (genvar k = 0; k < NCODES; k++) begin : g_code
      assign truth[k] = cond_eval(3'(k), cy, z, s);
   end

   assign taken = truth[code];
endmodule

// File: rtl/seq_core.sv
module seq_core
   import seq_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter int          INSN_W = 16,
   parameter logic [7:0]  RST_PC = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_in,
   output logic [DATA_W-1:0] fetch_addr,
   output logic [1:0]        phase_o,
   output logic              halted,
   output logic [2:0]        rd_a_sel,
   input  logic [DATA_W-1:0] rd_a_data,
   output logic [2:0]        rd_b_sel,
   input  logic [DATA_W-1:0] rd_b_data,
   output logic              rf_we,
   output logic [2:0]        rf_wsel,
   output logic [DATA_W-1:0] rf_wdata,
   output logic [DATA_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              alu_load,
   output logic [2:0]        alu_kind,
   output logic [1:0]        alu_unop,
   output logic [DATA_W-1:0] alu_opa,
   output logic [DATA_W-1:0] alu_opb,
   output logic              alu_wb,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_cy,
   input  logic              alu_z,
   input  logic              alu_s,
   output logic              flag_cy,
   output logic              flag_z,
   output logic              flag_s
);
   localparam int IMM3_PAD = DATA_W - 3;

   if (INSN_W != 2 * DATA_W) begin : g_bad_iw
      $error("seq_core: instruction width must be twice the data width");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("seq_core: encoding assumes an 8-bit data path");
   end

   phase_t              phase_q;
   logic [INSN_W-1:0]   ir_q;
   logic [DATA_W-1:0]   pc_q, inc_q;
   logic                halted_q, cy_q, z_q, s_q;

   dec_t                dec;
   logic                taken;
   logic [DATA_W-1:0]   val_a, val_b, imm;
   logic                wr_go, pc_wr, call_go;
   logic [2:0]          wr_sel;
   logic [DATA_W-1:0]   wr_val;

   seq_decode #(.INSN_W(INSN_W)) u_dec (.ir(ir_q), .dec(dec));

   seq_cond #(.COND_W(3)) u_cond (
      .code(dec.cond), .cy(cy_q), .z(z_q), .s(s_q), .taken(taken)
   );

   assign imm     = ir_q[DATA_W-1:0];
   assign val_a   = (dec.src_a == SEL_PC) ? inc_q : rd_a_data;
   assign val_b   = (dec.src_b == SEL_PC) ? inc_q : rd_b_data;
   assign call_go = (dec.kind == K_CALL) && taken;

   always_comb begin
      wr_go     = 1'b0;
      wr_sel    = dec.dst;
      wr_val    = '0;
      mem_we    = 1'b0;
      mem_addr  = imm;
      mem_wdata = val_a;
      if (dec.kind == K_LDP || dec.kind == K_STP) mem_addr = val_b;
      if (phase_q == PH_UPD && call_go) begin
         wr_go  = 1'b1;
         wr_sel = SEL_LINK;
         wr_val = inc_q;
      end
      if (phase_q == PH_EXEC) begin
         case (dec.kind)
            K_MOV:         begin wr_go = 1'b1;   wr_val = val_a;     end
            K_LDI, K_LDP:  begin wr_go = 1'b1;   wr_val = mem_rdata; end
            K_STI, K_STP:  mem_we = 1'b1;
            K_ALU:         begin wr_go = dec.wb; wr_val = alu_res;   end
            K_MOVI:        begin wr_go = taken;  wr_val = imm;       end
            K_CALL:        begin wr_go = taken;  wr_sel = SEL_PC; wr_val = imm; end
            default:       wr_go = 1'b0;
         endcase
      end
   end

   assign pc_wr    = wr_go && (wr_sel == SEL_PC);
   assign rf_we    = wr_go && (wr_sel != SEL_PC);
   assign rf_wsel  = wr_sel;
   assign rf_wdata = wr_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_FETCH;
         ir_q     <= '0;
         pc_q     <= RST_PC;
         inc_q    <= '0;
         halted_q <= 1'b0;
         cy_q     <= 1'b0;
         z_q      <= 1'b0;
         s_q      <= 1'b0;
      end else if (!halted_q) begin
         case (phase_q)
            PH_FETCH: begin
               ir_q    <= insn_in;
               inc_q   <= pc_q + 1'b1;
               phase_q <= PH_UPD;
            end
            PH_UPD: begin
               if (!call_go) pc_q <= inc_q;
               phase_q <= PH_EXEC;
            end
            default: begin
               if (pc_wr) pc_q <= wr_val;
               if (dec.kind == K_ALU) begin
                  cy_q <= alu_cy;
                  z_q  <= alu_z;
                  s_q  <= alu_s;
               end
               if (dec.kind == K_HALT) halted_q <= 1'b1;
               phase_q <= PH_FETCH;
            end
         endcase
      end
   end

   assign fetch_addr = pc_q;
   assign phase_o    = phase_q;
   assign halted     = halted_q;
   assign rd_a_sel   = dec.src_a;
   assign rd_b_sel   = dec.src_b;
   assign alu_load   = (phase_q == PH_UPD) && (dec.kind == K_ALU);
   assign alu_wb     = (phase_q == PH_EXEC) && (dec.kind == K_ALU) && dec.wb;
   assign alu_kind   = ir_q[13:11];
   assign alu_unop   = ir_q[2:1];
   assign alu_opa    = val_a;
   assign alu_opb    = dec.use_imm3 ? {{IMM3_PAD{1'b0}}, ir_q[2:0]} : val_b;
   assign flag_cy    = cy_q;
   assign flag_z     = z_q;
   assign flag_s     = s_q;

   // ---------------- assertions ----------------
   assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_q && phase_q == PH_FETCH) |=> (phase_q == PH_UPD));

   assert_upd_to_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_q && phase_q == PH_UPD) |=> (phase_q == PH_EXEC));

   assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> (halted_q && $stable(pc_q) && $stable(phase_q)));

   assert_store_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (phase_q == PH_EXEC && !rf_we));

   assert_alu_load_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alu_load |=> (phase_q == PH_EXEC));

   assert_link_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_UPD && rf_we) |-> (rf_wsel == SEL_LINK && rf_wdata == inc_q));

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_UPD && !halted_q && !call_go) |=> (pc_q == inc_q));
endmodule

// File: tb/seq_core_tb_top.sv
module seq_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] insn_in = 16'h0000;
   logic [7:0]  fetch_addr;
   logic [1:0]  phase_o;
   logic        halted;
   logic [2:0]  rd_a_sel, rd_b_sel, rf_wsel;
   logic [7:0]  rd_a_data, rd_b_data, rf_wdata;
   logic        rf_we, mem_we, alu_load, alu_wb;
   logic [7:0]  mem_addr, mem_wdata, mem_rdata;
   logic [2:0]  alu_kind;
   logic [1:0]  alu_unop;
   logic [7:0]  alu_opa, alu_opb, alu_res;
   logic        alu_cy, alu_z, alu_s;
   logic        flag_cy, flag_z, flag_s;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   seq_core dut_i (
      .clk(clk), .rst_n(rst_n), .insn_in(insn_in), .fetch_addr(fetch_addr),
      .phase_o(phase_o), .halted(halted),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
      .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .alu_load(alu_load), .alu_kind(alu_kind), .alu_unop(alu_unop),
      .alu_opa(alu_opa), .alu_opb(alu_opb), .alu_wb(alu_wb),
      .alu_res(alu_res), .alu_cy(alu_cy), .alu_z(alu_z), .alu_s(alu_s),
      .flag_cy(flag_cy), .flag_z(flag_z), .flag_s(flag_s)
   );

   // ---- external models: register file, data memory, ALU ----
   logic [7:0] rf [0:6];
   logic [7:0] dm [0:255];
   initial begin
      for (int i = 0; i < 7; i++) rf[i] = 8'h00;
      for (int i = 0; i < 256; i++) dm[i] = 8'h00;
   end
   assign rd_a_data = (rd_a_sel == 3'd7) ? 8'hEE : rf[rd_a_sel];
   assign rd_b_data = (rd_b_sel == 3'd7) ? 8'hEE : rf[rd_b_sel];
   assign mem_rdata = dm[mem_addr];
   always @(posedge clk) begin
      if (rf_we && rf_wsel != 3'd7) rf[rf_wsel] <= rf_wdata;
      if (mem_we) dm[mem_addr] <= mem_wdata;
   end

   logic [7:0] la, lb;
   logic [2:0] lk;
   logic [1:0] lu;
   logic       lc;
   always @(posedge clk) if (alu_load) begin
      la <= alu_opa; lb <= alu_opb; lk <= alu_kind; lu <= alu_unop; lc <= flag_cy;
   end
   logic [8:0] t9;
   always_comb begin
      t9 = 9'h000;
      case (lk)
         3'd0: t9 = {1'b0, la} + {1'b0, lb} + {8'h00, lc};
         3'd1: t9 = {1'b0, la} + {1'b0, lb};
         3'd2: t9 = {1'b0, la} - {1'b0, lb} - {8'h00, lc};
         3'd3: t9 = {1'b0, la} - {1'b0, lb};
         3'd4: t9 = {1'b0, la & lb};
         3'd5: t9 = {1'b0, la | lb};
         3'd6: t9 = {1'b0, la ^ lb};
         default: case (lu)
            2'd0: t9 = {1'b0, ~la};
            2'd1: t9 = {1'b0, la[0], la[7:1]};
            2'd2: t9 = {la[0], 1'b0, la[7:1]};
            default: t9 = {la[0], lc, la[7:1]};
         endcase
      endcase
   end
   assign alu_res = t9[7:0];
   assign alu_cy  = t9[8];
   assign alu_z   = (t9[7:0] == 8'h00);
   assign alu_s   = t9[7];

   // ---- reporting ----
   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         report();
      end
   end

   task automatic run_insn(logic [15:0] w);
      insn_in = w;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   // ---- vector table: word, expected PC, register to check (7 = none), value, {cy,z,s}, requirement ----
   typedef struct packed {
      logic [15:0] w;
      logic [7:0]  pc;
      logic [2:0]  sel;
      logic [7:0]  val;
      logic [2:0]  fl;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{16'h8005, 8'h01, 3'd0, 8'h05, 3'b000, 4'd4},   // R4 movi A
      '{16'h81FB, 8'h02, 3'd1, 8'hFB, 3'b000, 4'd4},   // R4 movi B
      '{16'h4809, 8'h03, 3'd0, 8'h00, 3'b110, 4'd9},   // R9 add A,A,B carry+zero
      '{16'h9277, 8'h04, 3'd2, 8'h77, 3'b110, 4'd3},   // R3 zero-set taken
      '{16'hE311, 8'h05, 3'd3, 8'h00, 3'b110, 4'd3},   // R3 zero-clear not taken
      '{16'hB740, 8'h40, 3'd7, 8'h00, 3'b110, 4'd4},   // R4 jump on carry
      '{16'h8F80, 8'h80, 3'd6, 8'h41, 3'b110, 4'd5},   // R5 call taken
      '{16'hFF10, 8'h81, 3'd6, 8'h41, 3'b110, 4'd3},   // R3 code 111 never
      '{16'h1B70, 8'h82, 3'd3, 8'h82, 3'b110, 4'd2},   // R2 mov D,PC
      '{16'h3230, 8'h83, 3'd7, 8'h00, 3'b110, 4'd8},   // R8 store imm
      '{16'h2330, 8'h84, 3'd3, 8'h77, 3'b110, 4'd7},   // R7 load imm
      '{16'h8430, 8'h85, 3'd4, 8'h30, 3'b110, 4'd4},   // R4 movi M
      '{16'h3904, 8'h86, 3'd7, 8'h00, 3'b110, 4'd8},   // R8 store via M
      '{16'h2804, 8'h87, 3'd0, 8'hFB, 3'b110, 4'd7},   // R7 load via M
      '{16'h5883, 8'h88, 3'd0, 8'hFB, 3'b001, 4'd9},   // R9 compare imm, no write
      '{16'h1F60, 8'h41, 3'd6, 8'h41, 3'b001, 4'd6},   // R6 return (mov PC,L)
      '{16'h7A0C, 8'h42, 3'd2, 8'h7D, 3'b100, 4'd9},   // R9 unary shift right
      '{16'h1000, 8'h43, 3'd7, 8'h00, 3'b100, 4'd10}   // R10 halt
   };

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 pc", {8'h0, fetch_addr}, 16'h0000);
      chk("R11 flags", {13'h0, flag_cy, flag_z, flag_s}, 16'h0000);
      chk("R11 halted/phase", {13'h0, halted, phase_o}, 16'h0000);

      // R1 phase walk with an ALU compare; R9 operand timing
      rst_n   = 1'b1;
      insn_in = 16'h5883;
      @(posedge clk); @(negedge clk);
      chk("R1 phase upd", {14'h0, phase_o}, 16'd1);
      chk("R9 load strobe", {15'h0, alu_load}, 16'd1);
      chk("R9 opb imm3", {8'h0, alu_opb}, 16'h0003);
      @(posedge clk); @(negedge clk);
      chk("R1 phase exec", {14'h0, phase_o}, 16'd2);
      chk("R9 no writeback", {14'h0, alu_wb, rf_we}, 16'd0);
      @(posedge clk); @(negedge clk);
      chk("R1 phase fetch", {14'h0, phase_o}, 16'd0);
      chk("R2 pc step", {8'h0, fetch_addr}, 16'h0001);

      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         run_insn(VECS[v].w);
         checks++;
         if (fetch_addr !== VECS[v].pc ||
             {flag_cy, flag_z, flag_s} !== VECS[v].fl ||
             (VECS[v].sel != 3'd7 && rf[VECS[v].sel] !== VECS[v].val)) begin
            fails++;
            $display("FAIL R%0d vec %0d: actual pc %h fl %b reg %h expected pc %h fl %b reg %h",
                     VECS[v].rq, v, fetch_addr, {flag_cy, flag_z, flag_s},
                     (VECS[v].sel == 3'd7) ? 8'h00 : rf[VECS[v].sel],
                     VECS[v].pc, VECS[v].fl, VECS[v].val);
         end
      end

      // R10 frozen after halt
      chk("R10 halted", {15'h0, halted}, 16'd1);
      insn_in = 16'h8099;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R10 pc held", {8'h0, fetch_addr}, 16'h0043);
      chk("R10 A untouched", {8'h0, rf[0]}, 16'h00FB);

      // R11 reset clears halt
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R11 halt cleared", {15'h0, halted}, 16'd0);
      chk("R11 pc and flags", {5'h0, flag_cy, flag_z, flag_s, fetch_addr}, 16'h0000);
      rst_n = 1'b1;
      run_insn(16'h8099);
      chk("R4 runs after reset", {8'h0, rf[0]}, 16'h0099);
      report();
   end
endmodule